// File: doc/BRIEF.md
# PCM Highway Transmit Output Control

This block sits at the transmit edge of a serial PCM highway interface with several ports. In every bit period it decides, for each port, whether the outgoing serial line carries switched voice or data bits, a programmed idle pattern, or nothing at all (high impedance). A separate timing generator supplies the slot index, the bit position inside the 8-bit slot and a one-cycle bit strobe. A switching memory supplies the byte that each port should send in the current slot. Both of these sit outside the block.

Each port owns a small slot table. An entry tells whether the slot is connected. For a slot that is not connected, the entry holds a 4-bit drive mask, one bit per pair of bit periods, that chooses between the idle value and high impedance. Every pad enable has a matching active-low strobe registered beside it, so that an external line buffer can be gated by it. A standby state floats every port at once. The slot tables, the idle register and the timing inputs keep working normally while standby is on.

Top module: `pcm_tx_drive`

## Requirements
- R1: While reset is applied and after it is released, every port shows txd_oe=0, tsc_n=1 and txd=0. The standby state is active, and every slot-table entry reads as not connected with drive mask 0000.
- R2: When a port's entry for slot_idx is connected and standby is off, a clock edge with bit_adv=1 and bit_idx=k drives txd = sw_data bit (7-k) of that port's byte and txd_oe=1. The most significant bit is therefore sent first.
- R3: When the entry is not connected and standby is off, mask bit bit_idx[2:1] decides the output. If that bit is 1, txd = idle_pat bit (7-k) and txd_oe=1. If it is 0, the port floats with txd_oe=0.
- R4: After stby_on, the next bit update floats every port, whatever the tables hold. Slot-table writes made during standby still take effect, and they show at once after stby_off.
- R5: When stby_on and stby_off are both high in one cycle, standby becomes (or stays) active.
- R6: txd, txd_oe and tsc_n change only on clock edges where bit_adv=1. On other edges they hold.
- R7: tsc_n is always the inverse of txd_oe, and both change on the same edge.
- R8: A table write (cfg_we=1) changes only the entry at (cfg_port, cfg_slot). Every other port and slot keeps its behaviour.
- R9: When a port floats, its txd reads 0.
- R10: In a connected slot the drive mask has no effect. All eight bit periods are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Slot-table write strobe |
| cfg_port | input | PORT_W | Port addressed by the write |
| cfg_slot | input | SLOT_W | Slot addressed by the write |
| cfg_conn | input | 1 | Written connected flag |
| cfg_mask | input | 4 | Written drive mask, bit g covers bit periods 2g and 2g+1 |
| idle_pat | input | 8 | Idle byte for driven unconnected bit pairs |
| stby_on | input | 1 | Enter standby (dominant) |
| stby_off | input | 1 | Leave standby |
| bit_adv | input | 1 | One-cycle strobe marking a bit boundary |
| bit_idx | input | 3 | Bit position in slot, 0 sent first |
| slot_idx | input | SLOT_W | Current slot number |
| sw_data | input | NPORT*8 | Switched byte per port, port p in bits 8p+7..8p |
| txd | output | NPORT | Serial transmit data per port |
| txd_oe | output | NPORT | Pad output enable per port |
| tsc_n | output | NPORT | Active-low external buffer strobe per port |

## Verification
The bench builds the block with four ports and four slots per port. With that size it can sweep every port, slot and bit position against a table held in the bench, and it can run the whole sweep again after each change of configuration. This covers each mask bit, both connection states and each bit-pair boundary, in every combination with different per-port bytes. The small size also lets the bench check the standby transitions, the case where both standby commands arrive in the same cycle, and the isolation of a single table write across the full address space.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int unsigned SLOT_BITS = 8;
  localparam int unsigned GRP_CNT   = SLOT_BITS / 2;

  typedef struct packed {
    logic                conn;
    logic [GRP_CNT-1:0]  mask;
  } slot_ent_t;

  // bit k of slot goes out first for k=0, taken from byte bit (7-k)
  function automatic logic msb_first(input logic [SLOT_BITS-1:0] b,
                                     input logic [2:0] k);
    return b[3'd7 - k];
  endfunction
endpackage

// File: rtl/pcm_slot_table.sv
module pcm_slot_table
  import pcm_tx_pkg::*;
#(
  parameter int unsigned NSLOT  = 32,
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] waddr,
  input  slot_ent_t         wdata,
  input  logic [SLOT_W-1:0] raddr,
  output slot_ent_t         rdata
);
  slot_ent_t mem_q [NSLOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/pcm_stby_ctl.sv
module pcm_stby_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_on,
  input  logic stby_off,
  output logic stby_act
);
  logic stby_d, stby_q;

  always_comb begin
    stby_d = stby_q;
    if (stby_on)       stby_d = 1'b1;
    else if (stby_off) stby_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stby_q <= 1'b1;
    else        stby_q <= stby_d;
  end

  assign stby_act = stby_q;
endmodule

// File: rtl/pcm_port_lane.sv
module pcm_port_lane
  import pcm_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_adv,
  input  logic [2:0]           bit_idx,
  input  logic                 stby_act,
  input  slot_ent_t            ent,
  input  logic [SLOT_BITS-1:0] sw_byte,
  input  logic [SLOT_BITS-1:0] idle_pat,
  output logic                 txd,
  output logic                 txd_oe,
  output logic                 tsc_n
);
  logic d_nxt, oe_nxt;
  logic d_q, oe_q, tsc_q;

  always_comb begin
    d_nxt  = 1'b0;
    oe_nxt = 1'b0;
    if (!stby_act) begin
      if (ent.conn) begin
        oe_nxt = 1'b1;
        d_nxt  = msb_first(sw_byte, bit_idx);
      end else if (ent.mask[bit_idx[2:1]]) begin
        oe_nxt = 1'b1;
        d_nxt  = msb_first(idle_pat, bit_idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q   <= 1'b0;
      oe_q  <= 1'b0;
      tsc_q <= 1'b1;
    end else if (bit_adv) begin
      d_q   <= d_nxt;
      oe_q  <= oe_nxt;
      tsc_q <= ~oe_nxt;
    end
  end

  assign txd    = d_q;
  assign txd_oe = oe_q;
  assign tsc_n  = tsc_q;
endmodule

// File: rtl/pcm_tx_drive.sv
module pcm_tx_drive
  import pcm_tx_pkg::*;
#(
  parameter int unsigned NPORT  = 4,
  parameter int unsigned NSLOT  = 32,
  localparam int unsigned PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [PORT_W-1:0]      cfg_port,
  input  logic [SLOT_W-1:0]      cfg_slot,
  input  logic                   cfg_conn,
  input  logic [3:0]             cfg_mask,
  input  logic [7:0]             idle_pat,
  input  logic                   stby_on,
  input  logic                   stby_off,
  input  logic                   bit_adv,
  input  logic [2:0]             bit_idx,
  input  logic [SLOT_W-1:0]      slot_idx,
  input  logic [NPORT*8-1:0]     sw_data,
  output logic [NPORT-1:0]       txd,
  output logic [NPORT-1:0]       txd_oe,
  output logic [NPORT-1:0]       tsc_n
);
  logic [1:0] rst_sh_q;
  logic       rst_sync_n;
  logic       stby_act;
  slot_ent_t  wr_ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sh_q[1];

  assign wr_ent = '{conn: cfg_conn, mask: cfg_mask};

  pcm_stby_ctl u_stby (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .stby_on  (stby_on),
    .stby_off (stby_off),
    .stby_act (stby_act)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    slot_ent_t rd_ent;
    logic      port_we;

    assign port_we = cfg_we && (cfg_port == PORT_W'(p));

    pcm_slot_table #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_tab (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .we    (port_we),
      .waddr (cfg_slot),
      .wdata (wr_ent),
      .raddr (slot_idx),
      .rdata (rd_ent)
    );

    pcm_port_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .bit_adv  (bit_adv),
      .bit_idx  (bit_idx),
      .stby_act (stby_act),
      .ent      (rd_ent),
      .sw_byte  (sw_data[p*8 +: 8]),
      .idle_pat (idle_pat),
      .txd      (txd[p]),
      .txd_oe   (txd_oe[p]),
      .tsc_n    (tsc_n[p])
    );
  end
endmodule

// File: rtl/pcm_tx_drive_chk.sv
module pcm_tx_drive_chk #(
  parameter int unsigned NPORT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_adv,
  input logic             stby_on,
  input logic             stby_act,
  input logic [NPORT-1:0] txd,
  input logic [NPORT-1:0] txd_oe,
  input logic [NPORT-1:0] tsc_n
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_adv) |-> ($stable(txd) && $stable(txd_oe) && $stable(tsc_n)));

  p_strobe_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tsc_n == ~txd_oe);

  p_stby_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stby_act) && $past(bit_adv)) |-> (txd_oe == '0));

  p_float_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (txd & ~txd_oe) == '0);

  p_on_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stby_on) |-> stby_act);
endmodule

bind pcm_tx_drive pcm_tx_drive_chk #(.NPORT(NPORT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bit_adv  (bit_adv),
  .stby_on  (stby_on),
  .stby_act (stby_act),
  .txd      (txd),
  .txd_oe   (txd_oe),
  .tsc_n    (tsc_n)
);

// File: tb/tb_pcm_tx_drive.sv
module tb_pcm_tx_drive;
  localparam int NP = 4;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, cfg_conn, stby_on, stby_off, bit_adv;
  logic [1:0]    cfg_port, cfg_slot, slot_idx;
  logic [3:0]    cfg_mask;
  logic [7:0]    idle_pat;
  logic [2:0]    bit_idx;
  logic [NP*8-1:0] sw_data;
  logic [NP-1:0] txd, txd_oe, tsc_n;

  int total = 0;
  int bad   = 0;
  logic       m_conn [NP][NS];
  logic [3:0] m_mask [NP][NS];

  always #2 clk = ~clk;

  pcm_tx_drive #(.NPORT(NP), .NSLOT(NS)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
    .cfg_slot(cfg_slot), .cfg_conn(cfg_conn), .cfg_mask(cfg_mask),
    .idle_pat(idle_pat), .stby_on(stby_on), .stby_off(stby_off),
    .bit_adv(bit_adv), .bit_idx(bit_idx), .slot_idx(slot_idx),
    .sw_data(sw_data), .txd(txd), .txd_oe(txd_oe), .tsc_n(tsc_n)
  );

  function automatic logic [7:0] swb(int p, int s);
    return 8'h3C ^ 8'((p * 37) + (s * 11));
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(logic ok, string req, logic [11:0] act, logic [11:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int p, int s, logic c, logic [3:0] m);
    cfg_we = 1'b1; cfg_port = 2'(p); cfg_slot = 2'(s);
    cfg_conn = c; cfg_mask = m;
    m_conn[p][s] = c; m_mask[p][s] = m;
    tick();
    cfg_we = 1'b0;
  endtask

  // one bit update and a check of every port against the model
  task automatic bit_check(int s, int b, logic stby);
    logic [11:0] exp, act;
    string req;
    slot_idx = 2'(s); bit_idx = 3'(b);
    for (int p = 0; p < NP; p++) sw_data[p*8 +: 8] = swb(p, s);
    bit_adv = 1'b1;
    tick();
    bit_adv = 1'b0;
    exp = '0; req = "R3";
    for (int p = 0; p < NP; p++) begin
      logic d, oe;
      d = 1'b0; oe = 1'b0;
      if (stby) req = "R4";
      else if (m_conn[p][s]) begin
        oe = 1'b1; d = swb(p, s)[7-b]; req = "R2";
      end else if (m_mask[p][s][b/2]) begin
        oe = 1'b1; d = idle_pat[7-b];
      end
      exp[p] = d; exp[4+p] = oe; exp[8+p] = ~oe;
    end
    act = {tsc_n, txd_oe, txd};
    check(act == exp, req, act, exp);
  endtask

  task automatic sweep(logic stby);
    for (int s = 0; s < NS; s++)
      for (int b = 0; b < 8; b++) bit_check(s, b, stby);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] hold;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_conn = 1'b0; cfg_port = '0; cfg_slot = '0;
    cfg_mask = '0; idle_pat = 8'hA5; stby_on = 1'b0; stby_off = 1'b0;
    bit_adv = 1'b0; bit_idx = '0; slot_idx = '0; sw_data = '0;
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NS; s++) begin m_conn[p][s] = 1'b0; m_mask[p][s] = '0; end
    repeat (3) tick();
    // R1: during reset
    check({tsc_n, txd_oe, txd} == 12'hF00, "R1", {tsc_n, txd_oe, txd}, 12'hF00);
    rst_n = 1'b1;
    repeat (4) tick();
    check({tsc_n, txd_oe, txd} == 12'hF00, "R1", {tsc_n, txd_oe, txd}, 12'hF00);
    // R1: standby active after reset, tables empty
    sweep(1'b1);
    stby_off = 1'b1; tick(); stby_off = 1'b0;
    sweep(1'b0); // R1: all entries unconnected, mask 0 -> float

    // R2 R3 R10 R9 R7: sweep over a mixed table
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NS; s++)
        wr(p, s, ((p + s) % 3) == 0, 4'((p * 5 + s * 3) & 15));
    sweep(1'b0);
    idle_pat = 8'h3B;
    sweep(1'b0);
    // R10: connected with every mask value still drives all bits
    for (int m = 0; m < 16; m++) begin
      wr(1, 2, 1'b1, 4'(m));
      for (int b = 0; b < 8; b++) bit_check(2, b, 1'b0);
    end
    // R3: every mask on an unconnected slot
    for (int m = 0; m < 16; m++) begin
      wr(3, 0, 1'b0, 4'(m));
      for (int b = 0; b < 8; b++) bit_check(0, b, 1'b0);
    end

    // R6: no bit_adv -> outputs hold
    bit_check(0, 0, 1'b0);
    hold = {tsc_n, txd_oe, txd};
    slot_idx = 2'd3; bit_idx = 3'd5; sw_data = ~sw_data; idle_pat = ~idle_pat;
    repeat (3) tick();
    check({tsc_n, txd_oe, txd} == hold, "R6", {tsc_n, txd_oe, txd}, hold);
    idle_pat = 8'h3B;

    // R4: standby floats, writes continue
    stby_on = 1'b1; tick(); stby_on = 1'b0;
    sweep(1'b1);
    wr(0, 1, 1'b1, 4'h0);
    wr(2, 3, 1'b0, 4'hF);
    stby_off = 1'b1; tick(); stby_off = 1'b0;
    sweep(1'b0); // R4: writes during standby visible

    // R5: both commands at once -> standby
    stby_on = 1'b1; stby_off = 1'b1; tick(); stby_on = 1'b0; stby_off = 1'b0;
    bit_check(0, 0, 1'b1);
    bit_check(1, 3, 1'b1);
    stby_off = 1'b1; tick(); stby_off = 1'b0;

    // R8: isolated write, full re-sweep checks all other entries
    wr(2, 1, ~m_conn[2][1], ~m_mask[2][1]);
    sweep(1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule